// File: doc/BRIEF.md
# Serial Audio Word Receiver with Mono, Pause and Framing Select

This block takes a three-wire serial audio stream (bit clock, channel select, data) produced by an external clock master, rebuilds 16-bit samples most significant bit first, and pushes the accepted samples into a receive FIFO through a simple write port. The serial wires are asynchronous to the system clock. They are resynchronised internally and sampled on the detected rising edge of the bit clock, so the system clock must run at least four times faster than the bit clock.

Channel select low marks a left-channel sample and high marks a right-channel sample. Two framings are supported: the standard one, in which the first data bit follows the channel-select transition by one bit period, and a left-justified one, in which the first data bit is already on the line when channel select changes. The storing policy makes sure that the FIFO always begins with a left sample. In mono mode right samples are discarded. A pause request takes effect, and is later lifted, only on left-sample boundaries. A sample that finds the FIFO full is lost and sets a sticky flag.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is held high on a clock edge, `wr_en` and `overrun` are 0 on the next cycle.
- R2: With `ljust_en`=0, a word starts at the second rising bit clock after a channel-select change. Its 16 bits are taken MSB first on consecutive rising bit clocks and written unchanged as `wr_data`.
- R3: With `ljust_en`=1, a word starts at the rising bit clock at which the channel-select change is first seen, and that bit is the MSB.
- R4: After reset, every word that completes before the first left word (channel select 0) starts is discarded. The first word written is therefore a left word.
- R5: In stereo mode (`mono_en`=0), left and right words are written in the order they arrive, one write per word.
- R6: With `mono_en`=1, words captured while channel select is 1 (right) are never written. Left words are still written.
- R7: `pause_req` is sampled when a left word starts. If it is 1 at that point, the left word and the right word that follows are not written. A change of `pause_req` during a frame does not affect that frame's words.
- R8: If `fifo_full` is 1 when a word that would be written completes, no write occurs and `overrun` becomes 1. It stays 1 until reset.
- R9: Bit-clock edges beyond the 16th bit of a word, before the next channel-select change, are ignored. They change neither the written word nor the number of writes.
- R10: `wr_en` is a one-cycle pulse per written word and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_in | input | 1 | Serial bit clock from the external master (asynchronous) |
| chan_sel_in | input | 1 | Channel select: 0 = left, 1 = right (asynchronous) |
| ser_data_in | input | 1 | Serial audio data (asynchronous) |
| pause_req | input | 1 | Request to suspend FIFO writes from the next left word |
| mono_en | input | 1 | 1 = keep only left words |
| ljust_en | input | 1 | 1 = left-justified framing, 0 = standard one-bit-delay framing |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| wr_en | output | 1 | FIFO write strobe, one cycle per word |
| wr_data | output | 16 | Word to be written, valid with `wr_en` |
| overrun | output | 1 | Sticky flag: a word was lost to a full FIFO |

## Verification
A bit counter that has slipped by one would show up on the first written word as a shifted value, one bit period after that word's last bit. Channel tracking is the other risk. A wrong channel or a wrong alignment state would show as a word written in the wrong order, a right word leaking through in mono mode, or a word that should have been written being missing. These errors appear at the write port within one frame of the stimulus that triggers them. A pause or overrun state that is latched wrongly shows as a whole frame too many or too few, or as a flag that does not match the moments when the FIFO was full.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int unsigned AUDRX_WORD_W_DEF = 16;
  localparam int unsigned AUDRX_SYNC_DEF   = 2;

endpackage

// File: rtl/audrx_bit_sync.sv
module audrx_bit_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in[g]};
      end
      assign sync_out[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/audrx_shifter.sv
module audrx_shifter
  import audrx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              ws_s,
  input  logic              sd_s,
  input  logic              ljust_en,
  output logic              start_p,
  output chan_e             start_ch,
  output logic              done_p,
  output logic [WORD_W-1:0] done_word,
  output chan_e             done_ch
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic              sck_q;
  logic              ws_prev;
  logic              pend;
  chan_e             pend_ch;
  chan_e             cur_ch;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  logic              bit_rise;
  logic              ws_chg;
  logic              begin_word;
  chan_e             begin_ch;
  logic              collecting;
  logic [WORD_W-1:0] sh_next;

  always_comb begin
    bit_rise   = sck_s & ~sck_q;
    ws_chg     = ws_s ^ ws_prev;
    begin_word = ljust_en ? ws_chg : pend;
    begin_ch   = ljust_en ? chan_e'(ws_s) : pend_ch;
    collecting = (cnt != FULL_CNT);
    sh_next    = {shreg[WORD_W-2:0], sd_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      ws_prev   <= 1'b0;
      pend      <= 1'b0;
      pend_ch   <= CH_LEFT;
      cur_ch    <= CH_LEFT;
      shreg     <= '0;
      cnt       <= FULL_CNT;
      start_p   <= 1'b0;
      start_ch  <= CH_LEFT;
      done_p    <= 1'b0;
      done_word <= '0;
      done_ch   <= CH_LEFT;
    end else begin
      sck_q   <= sck_s;
      start_p <= 1'b0;
      done_p  <= 1'b0;
      if (bit_rise) begin
        ws_prev <= ws_s;
        pend    <= ~ljust_en & ws_chg;
        pend_ch <= chan_e'(ws_s);
        if (begin_word) begin
          shreg    <= {{(WORD_W-1){1'b0}}, sd_s};
          cnt      <= ONE_CNT;
          cur_ch   <= begin_ch;
          start_p  <= 1'b1;
          start_ch <= begin_ch;
        end else if (collecting) begin
          shreg <= sh_next;
          cnt   <= cnt + ONE_CNT;
          if (cnt == LAST_CNT) begin
            done_p    <= 1'b1;
            done_word <= sh_next;
            done_ch   <= cur_ch;
          end
        end
      end
    end
  end

endmodule

// File: rtl/audrx_store_gate.sv
module audrx_store_gate
  import audrx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  chan_e             start_ch,
  input  logic              done_p,
  input  logic [WORD_W-1:0] done_word,
  input  chan_e             done_ch,
  input  logic              pause_req,
  input  logic              mono_en,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              overrun
);

  logic aligned;
  logic hold;
  logic keep;

  always_comb begin
    keep = aligned & ~hold & ~(mono_en & (done_ch == CH_RIGHT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned <= 1'b0;
      hold    <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      overrun <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_p && start_ch == CH_LEFT) begin
        aligned <= 1'b1;
        hold    <= pause_req;
      end
      if (done_p && keep) begin
        if (fifo_full) begin
          overrun <= 1'b1;
        end else begin
          wr_en   <= 1'b1;
          wr_data <= done_word;
        end
      end
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audrx_pkg::*;
#(
  parameter int unsigned WORD_W      = AUDRX_WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = AUDRX_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_clk_in,
  input  logic              chan_sel_in,
  input  logic              ser_data_in,
  input  logic              pause_req,
  input  logic              mono_en,
  input  logic              ljust_en,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              overrun
);

  localparam int unsigned N_SER = 3;

  logic [N_SER-1:0]  ser_raw;
  logic [N_SER-1:0]  ser_s;
  logic              start_p;
  chan_e             start_ch;
  logic              done_p;
  logic [WORD_W-1:0] done_word;
  chan_e             done_ch;

  assign ser_raw = {ser_data_in, chan_sel_in, bit_clk_in};

  audrx_bit_sync #(.WIDTH(N_SER), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (ser_raw),
    .sync_out (ser_s)
  );

  audrx_shifter #(.WORD_W(WORD_W)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (ser_s[0]),
    .ws_s      (ser_s[1]),
    .sd_s      (ser_s[2]),
    .ljust_en  (ljust_en),
    .start_p   (start_p),
    .start_ch  (start_ch),
    .done_p    (done_p),
    .done_word (done_word),
    .done_ch   (done_ch)
  );

  audrx_store_gate #(.WORD_W(WORD_W)) gate_i (
    .clk       (clk),
    .rst       (rst),
    .start_p   (start_p),
    .start_ch  (start_ch),
    .done_p    (done_p),
    .done_word (done_word),
    .done_ch   (done_ch),
    .pause_req (pause_req),
    .mono_en   (mono_en),
    .fifo_full (fifo_full),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .overrun   (overrun)
  );

endmodule

// File: rtl/audrx_checker.sv
module audrx_checker (
  input logic clk,
  input logic rst,
  input logic fifo_full,
  input logic mono_en,
  input logic wr_en,
  input logic overrun,
  input logic done_ch
);

  // R10: one strobe per word
  assert_wr_single_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R8: a full FIFO never receives a write
  assert_no_write_full_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(fifo_full));

  // R8: the flag stays set
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R8: the flag only rises because the FIFO was full
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(fifo_full));

  // R6: mono writes only left words
  assert_mono_left_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(mono_en)) |-> !$past(done_ch));

endmodule

bind audio_serial_rx audrx_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .fifo_full (fifo_full),
  .mono_en   (mono_en),
  .wr_en     (wr_en),
  .overrun   (overrun),
  .done_ch   (done_ch)
);

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int W          = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk = 1'b0;
  logic         chan = 1'b0;
  logic         sdat = 1'b0;
  logic         pause_req = 1'b0;
  logic         mono_en = 1'b0;
  logic         ljust_en = 1'b0;
  logic         fifo_full = 1'b0;
  logic         wr_en;
  logic [W-1:0] wr_data;
  logic         overrun;

  int           errors = 0;
  int           checks = 0;
  logic [W-1:0] exp_q[$];
  bit           seen_left = 0;
  bit           paused_m = 0;
  bit           ovr_exp = 0;
  string        cur_req = "R1";

  audio_serial_rx #(.WORD_W(W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .bit_clk_in  (bclk),
    .chan_sel_in (chan),
    .ser_data_in (sdat),
    .pause_req   (pause_req),
    .mono_en     (mono_en),
    .ljust_en    (ljust_en),
    .fifo_full   (fifo_full),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .overrun     (overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected write", int'(wr_data), 0);
      end else begin
        automatic logic [W-1:0] e = exp_q.pop_front();
        check(wr_data == e, cur_req, "written word", int'(wr_data), int'(e));
      end
    end
  end

  task automatic drive_slot(input bit ws, input bit b);
    @(negedge clk);
    bclk = 1'b0; chan = ws; sdat = b;
    repeat (HALF_BIT - 1) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
  endtask

  task automatic send_idle(input int n, input bit next_ch);
    for (int k = 0; k < n; k++)
      drive_slot((!ljust_en && k == n - 1) ? next_ch : 1'b0, 1'b0);
  endtask

  task automatic send_word(input bit ch, input logic [W-1:0] d,
                           input bit next_ch, input int extra);
    if (!ch) begin
      seen_left = 1;
      paused_m  = pause_req;
    end
    if (seen_left && !paused_m && !(mono_en && ch)) begin
      if (fifo_full) ovr_exp = 1;
      else           exp_q.push_back(d);
    end
    for (int k = 0; k < W + extra; k++) begin
      automatic bit b = (k < W) ? d[W-1-k] : 1'b1;
      automatic bit w = (!ljust_en && k == W + extra - 1) ? next_ch : ch;
      drive_slot(w, b);
    end
  endtask

  task automatic gap();
    repeat (8) @(negedge clk);
  endtask

  task automatic start_phase(input string req, input bit lj, input bit mono);
    rst = 1'b1; ljust_en = lj; mono_en = mono; pause_req = 1'b0;
    fifo_full = 1'b0; bclk = 1'b0; chan = 1'b0; sdat = 1'b0;
    repeat (4) @(negedge clk);
    check(wr_en == 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
    check(overrun == 1'b0, "R1", "overrun in reset", int'(overrun), 0);
    exp_q.delete(); seen_left = 0; paused_m = 0; ovr_exp = 0;
    cur_req = req;
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_phase();
    repeat (24) @(negedge clk);
    check(exp_q.size() == 0, cur_req, "words never written", exp_q.size(), 0);
    check(overrun == ovr_exp, "R8", "overrun flag", int'(overrun), int'(ovr_exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R2 R4 R5: standard framing, stereo, leading right word dropped
    start_phase("R2 R4 R5", 1'b0, 1'b0);
    send_idle(3, 1'b1);
    send_word(1'b1, 16'hDEAD, 1'b0, 0);
    send_word(1'b0, 16'hA5C3, 1'b1, 0);
    send_word(1'b1, 16'h8001, 1'b0, 0);
    send_word(1'b0, 16'hFFFF, 1'b1, 0);
    send_word(1'b1, 16'h0000, 1'b0, 0);
    send_word(1'b0, 16'h1234, 1'b1, 0);
    send_word(1'b1, 16'h7FFE, 1'b1, 0);
    end_phase();

    // R3 R4: left-justified framing
    start_phase("R3 R4", 1'b1, 1'b0);
    send_idle(3, 1'b0);
    send_word(1'b1, 16'hBEEF, 1'b0, 0);
    send_word(1'b0, 16'hC001, 1'b1, 0);
    send_word(1'b1, 16'h5AA5, 1'b0, 0);
    send_word(1'b0, 16'h0F0F, 1'b1, 0);
    send_word(1'b1, 16'h8000, 1'b1, 0);
    end_phase();

    // R6: mono keeps only left words
    start_phase("R6", 1'b0, 1'b1);
    send_idle(2, 1'b1);
    send_word(1'b1, 16'h1111, 1'b0, 0);
    send_word(1'b0, 16'h2468, 1'b1, 0);
    send_word(1'b1, 16'h3333, 1'b0, 0);
    send_word(1'b0, 16'hF00D, 1'b1, 0);
    send_word(1'b1, 16'h4444, 1'b0, 0);
    send_word(1'b0, 16'h0001, 1'b1, 0);
    send_word(1'b1, 16'h5555, 1'b1, 0);
    end_phase();

    // R7: pause applies and lifts only at left boundaries
    start_phase("R7", 1'b0, 1'b0);
    send_idle(2, 1'b1);
    send_word(1'b1, 16'h0BAD, 1'b0, 0);
    send_word(1'b0, 16'hA001, 1'b1, 0);
    send_word(1'b1, 16'hA002, 1'b0, 0);
    send_word(1'b0, 16'hB001, 1'b1, 0);
    gap(); pause_req = 1'b1;
    send_word(1'b1, 16'hB002, 1'b0, 0);
    send_word(1'b0, 16'hC001, 1'b1, 0);
    send_word(1'b1, 16'hC002, 1'b0, 0);
    send_word(1'b0, 16'hD001, 1'b1, 0);
    gap(); pause_req = 1'b0;
    send_word(1'b1, 16'hD002, 1'b0, 0);
    send_word(1'b0, 16'hE001, 1'b1, 0);
    send_word(1'b1, 16'hE002, 1'b1, 0);
    end_phase();

    // R8: full FIFO drops words and sets the sticky flag
    start_phase("R8", 1'b0, 1'b0);
    send_idle(2, 1'b1);
    send_word(1'b1, 16'h0000, 1'b0, 0);
    send_word(1'b0, 16'h1357, 1'b1, 0);
    send_word(1'b1, 16'h2468, 1'b0, 0);
    gap(); fifo_full = 1'b1;
    send_word(1'b0, 16'h9999, 1'b1, 0);
    send_word(1'b1, 16'h8888, 1'b0, 0);
    gap(); fifo_full = 1'b0;
    send_word(1'b0, 16'h7531, 1'b1, 0);
    send_word(1'b1, 16'h8642, 1'b1, 0);
    end_phase();

    // R9: extra bits after the 16th are ignored
    start_phase("R9", 1'b0, 1'b0);
    send_idle(2, 1'b1);
    send_word(1'b1, 16'h0000, 1'b0, 2);
    send_word(1'b0, 16'h6C3A, 1'b1, 3);
    send_word(1'b1, 16'h0102, 1'b0, 5);
    send_word(1'b0, 16'hFFFE, 1'b1, 1);
    send_word(1'b1, 16'h4000, 1'b1, 4);
    end_phase();

    // R9 in left-justified framing
    start_phase("R9 R3", 1'b1, 1'b0);
    send_idle(2, 1'b0);
    send_word(1'b1, 16'h0000, 1'b0, 2);
    send_word(1'b0, 16'h3C3C, 1'b1, 4);
    send_word(1'b1, 16'hC3C3, 1'b1, 3);
    end_phase();

    // R1: reset clears the sticky flag
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(overrun == 1'b0, "R1", "overrun after reset", int'(overrun), 0);
    check(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule